// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a byte-oriented asynchronous serial port that sits behind a small register port with 32-bit words. Software pushes bytes into an eight-entry transmit queue and pops bytes from an eight-entry receive queue. Each frame has a low start bit, eight data bits sent least significant bit first, no parity, and one or two high stop bits. A single programmable divisor sets the bit period for both directions.

Status does not sit in separate registers. Bit 31 of the transmit data word shows that the queue is full, and bit 31 of the receive data word shows that the queue was empty. A single read therefore reports emptiness and pops a byte in the same access. Each queue has a software-set watermark level. Each comparison against that level raises a pending bit that stays set as long as the condition holds. Each pending bit has its own enable, and the enabled bits are ORed onto one interrupt line.

Register accesses use a word index: 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 interrupt pending, 6 divisor. A read returns data in the same cycle, and any pop takes effect at the clock edge that ends the access.

Top module: `uart_wm_top`

## Requirements
- R1: After reset the tx line is high and irq is low. Both control words, the enable word and the pending word read as zero, the divisor reads 15, and a receive-data read shows bit 31 set.
- R2: A write to index 0 queues bits 7:0 unless the transmit queue already holds 8 bytes, in which case the byte is dropped. A read of index 0 returns 1 in bit 31 exactly when the queue is full.
- R3: Transmit control bit 0 enables sending. Bit 1 selects two stop bits when set and one when clear. A frame is a low start bit, data bits 0 through 7, then the stop bits, all high. Frames queued back to back start exactly 10 or 11 bit periods apart.
- R4: The divisor occupies bits 15:0 of index 6, and upper write bits are ignored. One bit period is the divisor plus one clock cycles.
- R5: A read of index 1 returns the oldest received byte in bits 7:0 with bit 31 clear and removes that byte. On an empty queue the read returns bit 31 set and changes nothing.
- R6: Receive control bit 0 enables reception. While it is clear, incoming frames are not stored.
- R7: When the receive queue already holds 8 bytes, a further received byte is dropped and the stored bytes are kept in order.
- R8: A start bit that reads high at its mid-point is rejected. A frame whose stop bit reads low at its mid-point is discarded, and the receiver then accepts the next good frame.
- R9: Pending bit 0 is set while the transmit occupancy is below the transmit watermark in control bits 18:16. Pending bit 1 is set while the receive occupancy is above the receive watermark in bits 18:16 of index 3. Writes to index 5 have no effect.
- R10: irq is the OR of the pending bits whose enable bits (index 4, bit 0 transmit, bit 1 receive) are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that at most one register access occurs per cycle. They also assume that the divisor is not changed while a transmit frame is in flight, because a counter already past a newly smaller limit would stretch the bit. The bench therefore waits out any frame before it reprograms the divisor. It drives rxd only with whole frames, or with deliberate short glitches, at the programmed bit period. Receive tests use a divisor of 15, which leaves enough margin that the two-flop input synchroniser does not push the mid-bit sample across a bit boundary.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 8;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int WM_W       = 3;
    localparam int DIV_W      = 16;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_TXQ   = 3'd0,
        REG_RXQ   = 3'd1,
        REG_TXCFG = 3'd2,
        REG_RXCFG = 3'd3,
        REG_IEN   = 3'd4,
        REG_IPEND = 3'd5,
        REG_DIV   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic [WM_W-1:0] wm;
        logic            two_stop;
        logic            en;
    } tx_cfg_t;

    typedef struct packed {
        logic [WM_W-1:0] wm;
        logic            en;
    } rx_cfg_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    function automatic logic [CNT_W-1:0] wm_ext(input logic [WM_W-1:0] w);
        return CNT_W'(w);
    endfunction
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_wm_tx.sv
module uart_wm_tx
    import uart_wm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              two_stop,
    input  logic              avail,
    input  logic [DATA_W-1:0] data,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 3;

    logic [FRAME_W-1:0] shreg;
    logic [3:0]         bits_left;
    logic [DIV_W-1:0]   cnt;
    logic               tick, last;

    assign busy = (bits_left != '0);
    assign tick = busy && (cnt == div);
    assign last = tick && (bits_left == 4'd1);
    assign take = avail && (!busy || last);
    assign txd  = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '1;
            bits_left <= '0;
            cnt       <= '0;
        end else if (take) begin
            shreg     <= {2'b11, data, 1'b0};
            bits_left <= two_stop ? 4'd11 : 4'd10;
            cnt       <= '0;
        end else if (busy) begin
            if (tick) begin
                shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
                cnt       <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_wm_rx.sv
module uart_wm_rx
    import uart_wm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    rx_state_e        state;
    logic             s1, s2, prev;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic             falling;

    assign falling = prev && !s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            prev  <= 1'b1;
            state <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            s1    <= rxd;
            s2    <= s1;
            prev  <= s2;
            valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (en && falling) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == (div >> 1)) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == div) begin
                        cnt  <= '0;
                        data <= {s2, data[DATA_W-1:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == div) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                        valid <= s2;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_wm_top.sv
module uart_wm_top
    import uart_wm_pkg::*;
#(
    parameter logic [15:0] DIV_RESET = 16'd15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);
    reg_sel_e          sel;
    logic              wr, rd;
    tx_cfg_t           tx_cfg;
    rx_cfg_t           rx_cfg;
    logic [1:0]        ien, ip;
    logic [DIV_W-1:0]  div;
    logic              tx_push, tx_take, tx_full, tx_empty, tx_busy;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:19], rx_full};
    assign sel     = reg_sel_e'(bus_addr);
    assign wr      = bus_valid && bus_write;
    assign rd      = bus_valid && !bus_write;
    assign tx_push = wr && (sel == REG_TXQ);
    assign rx_pop  = rd && (sel == REG_RXQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_cfg <= '0;
            rx_cfg <= '0;
            ien    <= '0;
            div    <= DIV_RESET;
        end else if (wr) begin
            case (sel)
                REG_TXCFG: tx_cfg <= '{wm: bus_wdata[18:16], two_stop: bus_wdata[1], en: bus_wdata[0]};
                REG_RXCFG: rx_cfg <= '{wm: bus_wdata[18:16], en: bus_wdata[0]};
                REG_IEN:   ien    <= bus_wdata[1:0];
                REG_DIV:   div    <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    assign ip  = {rx_count > wm_ext(rx_cfg.wm), tx_count < wm_ext(tx_cfg.wm)};
    assign irq = |(ip & ien);

    always_comb begin
        case (sel)
            REG_TXQ:   bus_rdata = {tx_full, 31'b0};
            REG_RXQ:   bus_rdata = {rx_empty, 23'b0, rx_head};
            REG_TXCFG: bus_rdata = {13'b0, tx_cfg.wm, 14'b0, tx_cfg.two_stop, tx_cfg.en};
            REG_RXCFG: bus_rdata = {13'b0, rx_cfg.wm, 15'b0, rx_cfg.en};
            REG_IEN:   bus_rdata = {30'b0, ien};
            REG_IPEND: bus_rdata = {30'b0, ip};
            REG_DIV:   bus_rdata = {16'b0, div};
            default:   bus_rdata = '0;
        endcase
    end

    uart_wm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
        .pop(tx_take), .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_wm_tx u_tx (
        .clk(clk), .rst(rst), .div(div), .two_stop(tx_cfg.two_stop),
        .avail(tx_cfg.en && !tx_empty), .data(tx_head), .take(tx_take),
        .busy(tx_busy), .txd(txd)
    );

    uart_wm_rx u_rx (
        .clk(clk), .rst(rst), .rxd(rxd), .en(rx_cfg.en), .div(div),
        .valid(rx_push), .data(rx_byte)
    );

    uart_wm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: rtl/uart_wm_checker.sv
module uart_wm_checker
    import uart_wm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             txd,
    input logic             irq,
    input logic             tx_busy,
    input logic             tx_push,
    input logic             tx_take,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic [1:0]       ien,
    input logic [1:0]       ip,
    input logic [WM_W-1:0]  tx_wm
);
    p_tx_bound_r2: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CNT_W'(FIFO_DEPTH));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_count == CNT_W'(FIFO_DEPTH) && !tx_take) |=> tx_count == CNT_W'(FIFO_DEPTH));

    p_idle_line_r3: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_count == '0 && !rx_push) |=> rx_count == '0);

    p_rx_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_count == CNT_W'(FIFO_DEPTH) && !rx_pop) |=> rx_count == CNT_W'(FIFO_DEPTH));

    p_tx_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_count == '0 && tx_wm != '0) |-> ip[0]);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien != 2'b00));
endmodule

bind uart_wm_top uart_wm_checker u_chk (
    .clk(clk), .rst(rst), .txd(txd), .irq(irq), .tx_busy(tx_busy),
    .tx_push(tx_push), .tx_take(tx_take), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_count(tx_count), .rx_count(rx_count), .ien(ien), .ip(ip), .tx_wm(tx_cfg.wm)
);

// File: tb/uart_wm_top_tb.sv
`timescale 1ns/1ps
module uart_wm_top_tb;
    localparam logic [2:0] A_TXQ = 3'd0, A_RXQ = 3'd1, A_TXCFG = 3'd2, A_RXCFG = 3'd3,
                           A_IEN = 3'd4, A_IP = 3'd5, A_DIV = 3'd6;
    localparam int RXP = 16;

    // {divisor, two stop bits, first byte, second byte}
    localparam logic [32:0] TXV [4] = '{
        {16'd3, 1'b0, 8'hA5, 8'h3C},
        {16'd3, 1'b1, 8'h01, 8'h80},
        {16'd7, 1'b0, 8'hFF, 8'h00},
        {16'd5, 1'b1, 8'h5A, 8'hC3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd, irq;
    logic        rxd = 1'b1;
    int          checks = 0, fails = 0, cyc = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_wm_top u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic tx_get(input int p, input bit two, output logic [7:0] b, output int t0);
        int guard = 0;
        b = '0;
        @(negedge clk);
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        t0 = cyc;
        if (guard >= 5000) begin
            chk("R3 start bit seen", 0, 1);
            return;
        end
        repeat (p + p / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            b[i] = txd;
            repeat (p) @(negedge clk);
        end
        chk("R3 stop bit high", {31'b0, txd}, 1);
        if (two) begin
            repeat (p) @(negedge clk);
            chk("R3 second stop bit high", {31'b0, txd}, 1);
        end
    endtask

    task automatic rx_send(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (RXP) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (RXP) @(negedge clk);
        end
        rxd = stop;
        repeat (RXP) @(negedge clk);
        rxd = 1'b1;
        repeat (RXP) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        logic [7:0] b0, b1;
        int t0, t1, lows;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 txd idle", {31'b0, txd}, 1);
        chk("R1 irq low", {31'b0, irq}, 0);
        rd(A_IP);    chk("R1 pending zero", rv, 0);
        rd(A_TXCFG); chk("R1 tx control zero", rv, 0);
        rd(A_RXCFG); chk("R1 rx control zero", rv, 0);
        rd(A_IEN);   chk("R1 enable zero", rv, 0);
        rd(A_DIV);   chk("R1 divisor 15", rv, 15);
        rd(A_RXQ);   chk("R1 rx empty flag", rv[31], 1);

        // R3 / R4 vector table
        for (int v = 0; v < 4; v++) begin
            int p;
            bit two;
            p = int'(TXV[v][32:17]) + 1;
            two = TXV[v][16];
            wr(A_TXCFG, {30'b0, two, 1'b0});
            wr(A_DIV, {16'b0, TXV[v][32:17]});
            wr(A_TXQ, {24'b0, TXV[v][15:8]});
            wr(A_TXQ, {24'b0, TXV[v][7:0]});
            rd(A_TXQ); chk("R2 not full with two", rv[31], 0);
            wr(A_TXCFG, {30'b0, two, 1'b1});
            tx_get(p, two, b0, t0);
            tx_get(p, two, b1, t1);
            chk("R3 first byte", {24'b0, b0}, {24'b0, TXV[v][15:8]});
            chk("R3 second byte", {24'b0, b1}, {24'b0, TXV[v][7:0]});
            chk("R3 R4 frame spacing", t1 - t0, (two ? 11 : 10) * p);
            wr(A_TXCFG, 0);
            repeat (4 * p) @(negedge clk);
        end

        // R2 full queue drops the ninth byte
        wr(A_DIV, 3);
        for (int i = 0; i < 9; i++) wr(A_TXQ, 32'h10 + i);
        rd(A_TXQ); chk("R2 full flag", rv[31], 1);
        wr(A_TXCFG, 32'h0001_0001);
        for (int i = 0; i < 8; i++) begin
            tx_get(4, 1'b0, b0, t0);
            chk("R2 queued byte order", {24'b0, b0}, 32'h10 + i);
        end
        lows = 0;
        repeat (120) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R2 ninth byte dropped", lows, 0);
        rd(A_TXQ); chk("R2 not full after drain", rv[31], 0);

        // R9 / R10 transmit watermark and gating
        rd(A_IP); chk("R9 tx pending empty below wm 1", rv, 1);
        wr(A_IP, 0);
        rd(A_IP); chk("R9 pending write ignored", rv, 1);
        wr(A_IEN, 1); @(negedge clk); chk("R10 irq tx enabled", {31'b0, irq}, 1);
        wr(A_IEN, 2); @(negedge clk); chk("R10 irq rx only", {31'b0, irq}, 0);
        wr(A_TXCFG, 32'h0000_0001);
        rd(A_IP); chk("R9 tx wm 0 never pending", rv, 0);

        // R4 divisor field
        wr(A_DIV, 32'hFFFF_0007);
        rd(A_DIV); chk("R4 upper bits ignored", rv, 7);
        wr(A_DIV, RXP - 1);

        // R5 basic receive
        wr(A_RXCFG, 1);
        rx_send(8'h6B, 1'b1);
        rd(A_IP); chk("R9 rx pending above wm 0", rv, 2);
        @(negedge clk); chk("R10 irq rx enabled", {31'b0, irq}, 1);
        rd(A_RXQ); chk("R5 byte read", rv, 32'h6B);
        rd(A_RXQ); chk("R5 empty read", rv[31], 1);
        rd(A_IP); chk("R9 rx pending clears", rv, 0);

        // R9 receive watermark 2
        wr(A_RXCFG, 32'h0002_0001);
        rx_send(8'h11, 1'b1);
        rx_send(8'h22, 1'b1);
        rd(A_IP); chk("R9 two not above wm 2", rv, 0);
        rx_send(8'h33, 1'b1);
        rd(A_IP); chk("R9 three above wm 2", rv, 2);
        rd(A_RXQ); chk("R5 order 1", rv, 32'h11);
        rd(A_RXQ); chk("R5 order 2", rv, 32'h22);
        rd(A_RXQ); chk("R5 order 3", rv, 32'h33);

        // R7 receive overflow
        wr(A_RXCFG, 1);
        for (int i = 0; i < 9; i++) rx_send(8'h40 + 8'(i), 1'b1);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXQ); chk("R7 kept byte", rv, 32'h40 + i);
        end
        rd(A_RXQ); chk("R7 ninth dropped", rv[31], 1);

        // R8 glitch and bad stop
        @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * RXP) @(negedge clk);
        rx_send(8'h77, 1'b0);
        rd(A_RXQ); chk("R8 glitch and bad stop discarded", rv[31], 1);
        rx_send(8'h99, 1'b1);
        rd(A_RXQ); chk("R8 recovers on good frame", rv, 32'h99);

        // R6 receive disabled
        wr(A_RXCFG, 0);
        rx_send(8'h12, 1'b1);
        rd(A_RXQ); chk("R6 disabled ignores frame", rv[31], 1);

        summary();
    end
endmodule